// File: doc/BRIEF.md
# Tagged Pointer Offset Unit

This execution unit advances a 64-bit tagged pointer by a small immediate number of 16-byte granules and rewrites the 4-bit logical tag carried inside the pointer. The new tag is found by stepping forward from the pointer's current tag through the 16 possible tag values, skipping any value that a 16-bit exclusion mask forbids. When tag access is turned off for the current privilege level, the tag field is cleared instead.

The unit takes the raw 32-bit instruction word and pulls the immediates and the register indices out of their fixed field positions. It presents the source index to the register file and receives both the general-register read value and the stack pointer. Index 31 selects the stack pointer for the source and for the destination. The result is registered once. It leaves the unit with a write strobe that goes to the stack pointer or to the general register file. Condition flags are neither read nor produced.

Top module: `tptr_offset_unit`

## Requirements
- R1: The address part of the result is the base plus the 6-bit immediate from instruction bits [21:16] times 16, computed modulo 2^64. Address bits [3:0] of the result equal those of the base.
- R2: Result bits [59:56] hold the chosen tag. Every other result bit equals the same bit of the sum, so a carry out of bit 55 into the tag field is overwritten.
- R3: When the tag immediate (instruction bits [13:10]) is 0, the chosen tag is the first value at or after the starting tag (base bits [59:56]), counting upward modulo 16, whose mask bit is clear.
- R4: When the tag immediate is k > 0, the chosen tag is found by stepping k times. Each step moves one value up, modulo 16, and then keeps moving past values whose mask bit is set. The count wraps from 15 to 0.
- R5: With tag access enabled, a tag whose mask bit is set never appears in the result. If all 16 mask bits are set, the tag is 0.
- R6: With tag access disabled, result bits [59:56] are 0 whatever the immediates and the mask are.
- R7: The source index is instruction bits [9:5]. It appears on `rd_addr` in the same cycle. Index 31 takes `sp_rdata` as the base, and any other index takes `gpr_rdata`.
- R8: The destination index is instruction bits [4:0]. When a result is valid, index 31 raises `wr_sp` and any other index raises `wr_gpr` with `wr_addr` set to that index. The two strobes are never high together and are low when no result is valid.
- R9: A result appears one clock after an accepted input. `out_valid` is low after reset and in any cycle that follows a cycle with no accepted input. The registered result is 0 after reset.
- R10: An input is accepted only when bits [31:22] and [15:14] of the instruction match the fixed pattern of word 0x91800000 (those bits being 1001000110 and 00). A non-matching word raises neither write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| insn | input | 32 | Instruction word |
| gpr_rdata | input | 64 | General register value at `rd_addr` |
| sp_rdata | input | 64 | Current stack pointer |
| excl_mask | input | 16 | Bit t set forbids tag value t |
| tag_en | input | 1 | Tag access enabled at the current privilege level |
| rd_addr | output | 5 | Source register index for the register file |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Registered tagged pointer result |
| wr_sp | output | 1 | Write result to the stack pointer |
| wr_gpr | output | 1 | Write result to general register `wr_addr` |
| wr_addr | output | 5 | Destination general register index |

## Verification
The stepping rule is tried against an independent reference model with several masks. An empty mask separates plain counting from skipping. Sparse masks (one or two forbidden values, alternating bits, both ends excluded) show that excluded values are skipped whether the excluded value is the start or lies along the path. A full mask and a cleared enable both show that the tag collapses to 0. Tag immediates of 0, 1, mid-range and 15 separate the "at or after" rule from the "strictly after" rule and exercise the wrap from 15 to 0. A base near the top of bit 55 shows that a carry into the tag field is overwritten. Source and destination indices of 31 and of other values are mixed, and a non-matching instruction word shows that the unit refuses the input.

// File: rtl/tptr_pkg.sv
package tptr_pkg;

    localparam int XLEN       = 64;
    localparam int TAG_W      = 4;
    localparam int NTAGS      = 1 << TAG_W;
    localparam int TAG_LO     = 56;
    localparam int AIMM_W     = 6;
    localparam int TIMM_W     = 4;
    localparam int IDX_W      = 5;
    localparam int GRANULE_SH = 4;
    localparam int INSN_W     = 32;

    localparam logic [IDX_W-1:0]  SP_IDX     = '1;
    localparam logic [INSN_W-1:0] FIXED_MASK = 32'hFFC0_C000;
    localparam logic [INSN_W-1:0] FIXED_VAL  = 32'h9180_0000;

    typedef struct packed {
        logic [AIMM_W-1:0] aimm;
        logic [TIMM_W-1:0] timm;
        logic [IDX_W-1:0]  src;
        logic [IDX_W-1:0]  dst;
    } fields_t;

    typedef struct packed {
        logic              valid;
        logic              to_sp;
        logic [IDX_W-1:0]  dst;
        logic [XLEN-1:0]   value;
    } wb_t;

    function automatic fields_t split_insn(input logic [INSN_W-1:0] w);
        fields_t f;
        f.aimm = w[21:16];
        f.timm = w[13:10];
        f.src  = w[9:5];
        f.dst  = w[4:0];
        return f;
    endfunction

    function automatic logic insn_matches(input logic [INSN_W-1:0] w);
        return (w & FIXED_MASK) == FIXED_VAL;
    endfunction

    // First permitted tag scanning upward from 'from' (or from 'from'+1
    // when strict is set), modulo NTAGS. Returns 0 if none is permitted.
    function automatic logic [TAG_W-1:0] skip_fwd(
        input logic [TAG_W-1:0] from,
        input logic [NTAGS-1:0] excl,
        input logic             strict
    );
        logic [TAG_W-1:0] res;
        logic [TAG_W-1:0] cand;
        logic             found;
        res   = '0;
        found = 1'b0;
        for (int i = 0; i < NTAGS; i++) begin
            cand = from + TAG_W'(i) + TAG_W'(strict);
            if (!found && !excl[cand]) begin
                res   = cand;
                found = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/tptr_operand_sel.sv
module tptr_operand_sel
    import tptr_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   gpr_rdata,
    input  logic [XLEN-1:0]   sp_rdata,
    output fields_t           fields,
    output logic              fmt_ok,
    output logic [XLEN-1:0]   base
);

    always_comb begin
        fields = split_insn(insn);
        fmt_ok = insn_matches(insn);
        base   = (fields.src == SP_IDX) ? sp_rdata : gpr_rdata;
    end

endmodule

// File: rtl/tptr_addr_add.sv
module tptr_addr_add
    import tptr_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int IMM_W = AIMM_W,
    parameter int SHIFT = GRANULE_SH
) (
    input  logic [W-1:0]     base,
    input  logic [IMM_W-1:0] imm,
    output logic [W-1:0]     sum
);

    localparam int OFF_W = IMM_W + SHIFT;

    logic [OFF_W-1:0] offset;

    always_comb begin
        offset = {imm, {SHIFT{1'b0}}};
        sum    = base + W'(offset);
    end

endmodule

// File: rtl/tptr_tag_step.sv
module tptr_tag_step
    import tptr_pkg::*;
#(
    parameter int CNT_W = TIMM_W
) (
    input  logic [TAG_W-1:0] start,
    input  logic [CNT_W-1:0] count,
    input  logic [NTAGS-1:0] excl,
    input  logic             en,
    output logic [TAG_W-1:0] tag
);

    localparam int NSTEP = 1 << CNT_W;

    logic [TAG_W-1:0] stage [NSTEP];
    logic             all_ex;

    // stage[0]: at-or-after the start; stage[k], k>0: k strict steps
    assign stage[0] = skip_fwd(start, excl, 1'b0);

    generate
        for (genvar k = 1; k < NSTEP; k++) begin : g_step
            if (k == 1) begin : g_first
                assign stage[k] = skip_fwd(start, excl, 1'b1);
            end else begin : g_chain
                assign stage[k] = skip_fwd(stage[k-1], excl, 1'b1);
            end
        end
    endgenerate

    always_comb begin
        all_ex = &excl;
        tag    = (!en || all_ex) ? '0 : stage[count];
    end

    // R5: a forbidden value never leaves the stepper while some value is permitted
    always_comb begin
        if (!$isunknown({start, count, excl, en}) && en && !all_ex) begin
            p_tag_allowed_r5: assert (!excl[tag]);
        end
    end

endmodule

// File: rtl/tptr_offset_unit.sv
module tptr_offset_unit
    import tptr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [INSN_W-1:0]   insn,
    input  logic [XLEN-1:0]     gpr_rdata,
    input  logic [XLEN-1:0]     sp_rdata,
    input  logic [NTAGS-1:0]    excl_mask,
    input  logic                tag_en,
    output logic [IDX_W-1:0]    rd_addr,
    output logic                out_valid,
    output logic [XLEN-1:0]     result,
    output logic                wr_sp,
    output logic                wr_gpr,
    output logic [IDX_W-1:0]    wr_addr
);

    fields_t          fld;
    logic             fmt_ok;
    logic [XLEN-1:0]  base;
    logic [XLEN-1:0]  sum;
    logic [TAG_W-1:0] new_tag;
    logic [XLEN-1:0]  merged;
    wb_t              wb_d;
    wb_t              wb_q;

    tptr_operand_sel u_sel (
        .insn      (insn),
        .gpr_rdata (gpr_rdata),
        .sp_rdata  (sp_rdata),
        .fields    (fld),
        .fmt_ok    (fmt_ok),
        .base      (base)
    );

    tptr_addr_add #(
        .W     (XLEN),
        .IMM_W (AIMM_W),
        .SHIFT (GRANULE_SH)
    ) u_add (
        .base (base),
        .imm  (fld.aimm),
        .sum  (sum)
    );

    tptr_tag_step #(
        .CNT_W (TIMM_W)
    ) u_tag (
        .start (base[TAG_LO +: TAG_W]),
        .count (fld.timm),
        .excl  (excl_mask),
        .en    (tag_en),
        .tag   (new_tag)
    );

    always_comb begin
        merged                   = sum;
        merged[TAG_LO +: TAG_W]  = new_tag;
        wb_d.valid               = in_valid && fmt_ok;
        wb_d.to_sp               = (fld.dst == SP_IDX);
        wb_d.dst                 = fld.dst;
        wb_d.value               = merged;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q <= '0;
        end else begin
            wb_q.valid <= wb_d.valid;
            if (wb_d.valid) begin
                wb_q.to_sp <= wb_d.to_sp;
                wb_q.dst   <= wb_d.dst;
                wb_q.value <= wb_d.value;
            end
        end
    end

    assign rd_addr   = fld.src;
    assign out_valid = wb_q.valid;
    assign result    = wb_q.value;
    assign wr_sp     = wb_q.valid && wb_q.to_sp;
    assign wr_gpr    = wb_q.valid && !wb_q.to_sp;
    assign wr_addr   = wb_q.dst;

    // R9 / R10: result follows an accepted input by one clock
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_ok) |=> out_valid);
    p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && fmt_ok) |=> !out_valid);

    // R8: exactly one write target per valid result
    p_one_target_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot({wr_sp, wr_gpr}));
    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(wr_sp || wr_gpr));

    // R1: granule-aligned offset leaves the low nibble of the base intact
    p_low_bits_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_ok) |=> result[GRANULE_SH-1:0] == $past(base[GRANULE_SH-1:0]));

    // R6: disabled tag access clears the tag field
    p_disabled_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_ok && !tag_en) |=> result[TAG_LO +: TAG_W] == '0);

    // R7: stack pointer chosen for source index 31
    p_sp_source_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_ok && fld.src == SP_IDX && fld.aimm == '0)
            |=> result[TAG_LO-1:0] == $past(sp_rdata[TAG_LO-1:0]));

endmodule

// File: tb/sim_tptr_offset_unit.sv
module sim_tptr_offset_unit;

    typedef struct packed {
        logic [5:0]  aimm;
        logic [3:0]  timm;
        logic [4:0]  src;
        logic [4:0]  dst;
        logic [63:0] base;
        logic [15:0] excl;
        logic        en;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{6'd1,  4'd0,  5'd3,  5'd4,  64'h0A00_0000_0000_1234, 16'h0000, 1'b1},
        '{6'd8,  4'd3,  5'd31, 5'd2,  64'h0500_1000_2000_3000, 16'h00A0, 1'b1},
        '{6'd63, 4'd15, 5'd7,  5'd31, 64'hF3FF_FFFF_FFFF_FC00, 16'h8001, 1'b1},
        '{6'd0,  4'd5,  5'd31, 5'd31, 64'h0C00_0000_0000_0010, 16'h5555, 1'b1},
        '{6'd2,  4'd1,  5'd0,  5'd9,  64'h0F00_0000_0000_0000, 16'h0000, 1'b1},
        '{6'd17, 4'd2,  5'd12, 5'd13, 64'h0700_ABCD_0000_0000, 16'h0000, 1'b0},
        '{6'd4,  4'd3,  5'd1,  5'd1,  64'h0500_0000_0000_0040, 16'hFFFF, 1'b1},
        '{6'd0,  4'd0,  5'd5,  5'd6,  64'h0900_0000_0000_0000, 16'h0200, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] insn;
    logic [63:0] gpr_rdata;
    logic [63:0] sp_rdata;
    logic [15:0] excl_mask;
    logic        tag_en;
    logic [4:0]  rd_addr;
    logic        out_valid;
    logic [63:0] result;
    logic        wr_sp;
    logic        wr_gpr;
    logic [4:0]  wr_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tptr_offset_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .insn      (insn),
        .gpr_rdata (gpr_rdata),
        .sp_rdata  (sp_rdata),
        .excl_mask (excl_mask),
        .tag_en    (tag_en),
        .rd_addr   (rd_addr),
        .out_valid (out_valid),
        .result    (result),
        .wr_sp     (wr_sp),
        .wr_gpr    (wr_gpr),
        .wr_addr   (wr_addr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] encode(input vec_t v);
        return 32'h9180_0000 | (32'(v.aimm) << 16) | (32'(v.timm) << 10)
             | (32'(v.src) << 5) | 32'(v.dst);
    endfunction

    function automatic logic [3:0] ref_tag(input logic [3:0] s, input logic [3:0] k,
                                           input logic [15:0] m, input logic en);
        logic [3:0] t;
        if (!en || m == 16'hFFFF) return 4'h0;
        t = s;
        if (k == 0) begin
            for (int j = 0; j < 16; j++) if (m[t]) t = t + 4'd1;
        end else begin
            for (int i = 0; i < int'(k); i++) begin
                t = t + 4'd1;
                for (int j = 0; j < 16; j++) if (m[t]) t = t + 4'd1;
            end
        end
        return t;
    endfunction

    function automatic logic [63:0] ref_result(input vec_t v);
        logic [63:0] r;
        r = v.base + (64'(v.aimm) << 4);
        r[59:56] = ref_tag(v.base[59:56], v.timm, v.excl, v.en);
        return r;
    endfunction

    // drive one vector, sample one clock later at the falling edge
    task automatic run(input vec_t v, input logic [31:0] word, input string req,
                       output logic [63:0] got);
        @(negedge clk);
        insn      = word;
        in_valid  = 1'b1;
        excl_mask = v.excl;
        tag_en    = v.en;
        gpr_rdata = (v.src == 5'd31) ? ~v.base : v.base;
        sp_rdata  = (v.src == 5'd31) ? v.base  : ~v.base;
        #1;
        check("R7 rd_addr", 64'(rd_addr), 64'(v.src));
        @(negedge clk);
        got = result;
        check({req, " out_valid"}, 64'(out_valid), 64'(1));
        check("R8 wr_sp", 64'(wr_sp), 64'(v.dst == 5'd31));
        check("R8 wr_gpr", 64'(wr_gpr), 64'(v.dst != 5'd31));
        if (v.dst != 5'd31) check("R8 wr_addr", 64'(wr_addr), 64'(v.dst));
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] got;
        vec_t        d;
        rst       = 1'b1;
        in_valid  = 1'b0;
        insn      = '0;
        gpr_rdata = '0;
        sp_rdata  = '0;
        excl_mask = '0;
        tag_en    = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset out_valid", 64'(out_valid), 64'(0));
        check("R9 reset result", result, 64'h0);
        check("R8 reset strobes", 64'({wr_sp, wr_gpr}), 64'(0));
        rst = 1'b0;

        // table walk against the reference model (R1..R6)
        for (int i = 0; i < NV; i++) begin
            run(VT[i], encode(VT[i]), "R9", got);
            check($sformatf("R1 R2 R3 R4 R5 R6 vec%0d", i), got, ref_result(VT[i]));
        end

        // R9: idle cycle produces no result
        @(negedge clk);
        check("R9 idle out_valid", 64'(out_valid), 64'(0));
        check("R8 idle strobes", 64'({wr_sp, wr_gpr}), 64'(0));

        // R2: carry out of bit 55 lands in tag field and is overwritten
        d = '{6'd1, 4'd0, 5'd2, 5'd3, 64'h00FF_FFFF_FFFF_FFF0, 16'h0000, 1'b1};
        run(d, encode(d), "R9", got);
        check("R2 carry overwritten", got, 64'h0);

        // R4: wrap from 15 to 0
        d = '{6'd2, 4'd1, 5'd4, 5'd5, 64'h0F00_0000_0000_0000, 16'h0000, 1'b1};
        run(d, encode(d), "R9", got);
        check("R4 wrap 15 to 0", got, 64'h0000_0000_0000_0020);

        // R4: skip excluded 4 and 5 after start 3
        d = '{6'd0, 4'd1, 5'd6, 5'd7, 64'h0300_0000_0000_0000, 16'h0030, 1'b1};
        run(d, encode(d), "R9", got);
        check("R4 skip excluded", got, 64'h0600_0000_0000_0000);

        // R3: tag immediate 0 with start excluded moves to next permitted
        d = '{6'd0, 4'd0, 5'd6, 5'd7, 64'h0E00_0000_0000_0100, 16'hC000, 1'b1};
        run(d, encode(d), "R9", got);
        check("R3 at-or-after", got, 64'h0000_0000_0000_0100);

        // R5: all excluded gives 0
        d = '{6'd0, 4'd7, 5'd8, 5'd9, 64'h0B00_0000_0000_0000, 16'hFFFF, 1'b1};
        run(d, encode(d), "R9", got);
        check("R5 all excluded", got, 64'h0);

        // R6: disabled gives tag 0 even with a sparse mask
        d = '{6'd3, 4'd9, 5'd31, 5'd31, 64'h0D00_0000_0000_0000, 16'h0001, 1'b0};
        run(d, encode(d), "R9", got);
        check("R6 disabled tag", got, 64'h0000_0000_0000_0030);

        // R10: non-matching instruction word is refused
        @(negedge clk);
        insn     = encode(d) ^ 32'h0000_4000;
        in_valid = 1'b1;
        @(negedge clk);
        check("R10 bad word out_valid", 64'(out_valid), 64'(0));
        check("R10 bad word strobes", 64'({wr_sp, wr_gpr}), 64'(0));
        insn = encode(d) ^ 32'h8000_0000;
        @(negedge clk);
        check("R10 bad opcode out_valid", 64'(out_valid), 64'(0));
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule